// File: doc/BRIEF.md
# Coherent Correlating Chip Despreader

This block turns one received symbol's worth of signed soft chip values into a symbol decision. It holds a bank of correlators, one per candidate spreading sequence, and every candidate is derived on the fly from a single programmable root word. A candidate is the root rotated by an even number of chip positions. For the upper half of the symbol values, the odd-numbered chips are also inverted. Each incoming chip is multiplied by the ±1 reference chip of every candidate, and the products are summed over the symbol. When the symbol ends, the candidate with the largest signed sum is reported together with that sum.

A receiver front end marks the start of each symbol with a one-cycle strobe. It then delivers chips with a valid flag, at any pace. The strobe captures the chip-length mode (8 or 16 chips), the cyclic-extension enable and the root. With extension enabled, each symbol carries one extra leading chip, which is discarded before correlation. The decision appears as a one-cycle pulse.

Top module: `coh_despreader`

## Requirements
- R1: After reset, `sym_valid_o` is 0, `sym_idx_o` is 0 and `peak_o` is 0.
- R2: With `mode_i`=1 (16-chip), candidate k (0..15) has chip j = `root_i[(j - 2*(k mod 8)) mod 16]`, with that chip inverted when k >= 8 and j is odd. Chip j is the j-th correlated chip of the symbol, counting from 0.
- R3: With `mode_i`=0 (8-chip), only `root_i[7:0]` is used. Candidate k (0..7) has chip j = `root_i[(j - 2*(k mod 4)) mod 8]`, inverted when k >= 4 and j is odd. `sym_idx_o[3]` is then always 0.
- R4: A reference bit of 1 weighs the chip +1 and a bit of 0 weighs it -1. The chip is 6-bit two's complement. `peak_o` is the exact 11-bit signed sum, with no overflow even for 16 full-scale chips.
- R5: The reported index is the one with the largest signed correlation. On a tie, the lowest index wins (all-zero chips give index 0, peak 0).
- R6: With extension captured as 1, the first valid chip after the start strobe is discarded, and the symbol takes 9 or 17 valid chips in total.
- R7: `sym_valid_o` is a one-cycle pulse in the cycle after the final valid chip. Cycles with `chip_valid_i`=0 are not counted, whatever the gaps.
- R8: `sym_start_i` clears the correlators and captures `mode_i`, `ext_en_i` and `root_i`. Later changes to these inputs have no effect until the next strobe. A chip presented in the strobe cycle is ignored. A strobe in the middle of a symbol abandons that symbol with no output.
- R9: Valid chips arriving after a symbol has completed and before the next strobe are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_start_i | input | 1 | Symbol start strobe |
| chip_valid_i | input | 1 | Soft chip present this cycle |
| chip_i | input | 6 | Signed soft chip value |
| mode_i | input | 1 | 1 = 16-chip set, 0 = 8-chip set |
| ext_en_i | input | 1 | Leading cyclic-extension chip present |
| root_i | input | 16 | Root sequence bits, bit 0 is chip 0 |
| sym_valid_o | output | 1 | Decision valid pulse |
| sym_idx_o | output | 4 | Decided symbol index |
| peak_o | output | 11 | Signed correlation of the decided symbol |

## Verification
The bench builds the block with its package defaults: 6-bit chips and a 16-chip maximum length. This makes the widest sum (±512) reachable with full-scale chips, and lets both the 8-chip and 16-chip sets run in one build. At these sizes every candidate of both sets can be decoded cleanly, and all sums can be compared exactly against a rotation-based reference model. Extension chips, gapped valid patterns, strobes in the middle of a symbol, and input changes after the strobe are all covered.

// File: rtl/cd_pkg.sv
package cd_pkg;

    parameter int CHIP_W = 6;
    parameter int N_MAX  = 16;

    localparam int IDX_W = $clog2(N_MAX);
    localparam int SYM_W = IDX_W;
    localparam int ACC_W = CHIP_W + IDX_W + 1;
    localparam int CNT_W = $clog2(N_MAX + 2);

    typedef logic signed [CHIP_W-1:0] chip_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } cd_mode_e;

    typedef struct packed {
        logic             acc_en;
        logic             last;
        logic             clear;
        logic [IDX_W-1:0] pos;
    } cd_step_t;

    typedef struct packed {
        logic [SYM_W-1:0] idx;
        acc_t             peak;
    } cd_pick_t;

    // Number of correlated chips for a mode
    function automatic int seq_len(input cd_mode_e m);
        return (m == MODE_LONG) ? N_MAX : N_MAX / 2;
    endfunction

    // Reference bit of candidate k at correlated chip position pos
    function automatic logic ref_chip(input logic [N_MAX-1:0] root,
                                      input cd_mode_e m,
                                      input int k,
                                      input logic [IDX_W-1:0] pos);
        int n;
        int half;
        int base;
        int p;
        logic b;
        n    = seq_len(m);
        half = n / 2;
        base = k % half;
        p    = ((int'(pos) - 2 * base) % n + n) % n;
        b    = root[p];
        if (((k % n) >= half) && pos[0])
            b = ~b;
        return b;
    endfunction

endpackage

// File: rtl/cd_ctrl.sv
module cd_ctrl
    import cd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_start_i,
    input  logic             chip_valid_i,
    input  logic             mode_i,
    input  logic             ext_en_i,
    input  logic [N_MAX-1:0] root_i,
    output cd_step_t         step_o,
    output cd_mode_e         mode_o,
    output logic [N_MAX-1:0] root_o
);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    cd_mode_e         mode_q;
    logic             ext_q;
    logic [N_MAX-1:0] root_q;

    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] pos_full;
    logic             take;
    logic             is_ext;

    always_comb begin
        total    = CNT_W'(seq_len(mode_q)) + {{(CNT_W-1){1'b0}}, ext_q};
        take     = active_q && chip_valid_i && !sym_start_i;
        is_ext   = ext_q && (cnt_q == '0);
        pos_full = cnt_q - {{(CNT_W-1){1'b0}}, ext_q};

        step_o.clear  = sym_start_i;
        step_o.acc_en = take && !is_ext;
        step_o.last   = take && (cnt_q == total - 1'b1);
        step_o.pos    = pos_full[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            mode_q   <= MODE_SHORT;
            ext_q    <= 1'b0;
            root_q   <= '0;
        end else if (sym_start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            mode_q   <= cd_mode_e'(mode_i);
            ext_q    <= ext_en_i;
            root_q   <= root_i;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (step_o.last)
                active_q <= 1'b0;
        end
    end

    assign mode_o = mode_q;
    assign root_o = root_q;

endmodule

// File: rtl/cd_refgen.sv
module cd_refgen
    import cd_pkg::*;
(
    input  cd_mode_e         mode_i,
    input  logic [N_MAX-1:0] root_i,
    input  logic [IDX_W-1:0] pos_i,
    output logic [N_MAX-1:0] ref_o
);

    for (genvar k = 0; k < N_MAX; k++) begin : g_cand
        assign ref_o[k] = ref_chip(root_i, mode_i, k, pos_i);
    end

endmodule

// File: rtl/cd_corr_bank.sv
module cd_corr_bank
    import cd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear_i,
    input  logic                   acc_en_i,
    input  chip_t                  chip_i,
    input  logic [N_MAX-1:0]       ref_i,
    output acc_t [N_MAX-1:0]       sum_o
);

    acc_t chip_ext;
    assign chip_ext = acc_t'(chip_i);

    for (genvar k = 0; k < N_MAX; k++) begin : g_mac
        acc_t acc_q;
        acc_t prod;
        acc_t nxt;

        always_comb begin
            prod = ref_i[k] ? chip_ext : -chip_ext;
            nxt  = acc_en_i ? (acc_q + prod) : acc_q;
        end

        always_ff @(posedge clk) begin
            if (rst || clear_i)
                acc_q <= '0;
            else if (acc_en_i)
                acc_q <= nxt;
        end

        assign sum_o[k] = nxt;
    end

endmodule

// File: rtl/cd_peak_pick.sv
module cd_peak_pick
    import cd_pkg::*;
(
    input  cd_mode_e         mode_i,
    input  acc_t [N_MAX-1:0] sum_i,
    output cd_pick_t         pick_o
);

    always_comb begin
        acc_t best;
        acc_t cand;
        logic [SYM_W-1:0] best_idx;
        best     = sum_i[0];
        best_idx = '0;
        for (int k = 1; k < N_MAX; k++) begin
            cand = sum_i[k];
            if ((k < seq_len(mode_i)) && (cand > best)) begin
                best     = cand;
                best_idx = SYM_W'(k);
            end
        end
        pick_o.idx  = best_idx;
        pick_o.peak = best;
    end

endmodule

// File: rtl/coh_despreader.sv
module coh_despreader
    import cd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_start_i,
    input  logic             chip_valid_i,
    input  logic [CHIP_W-1:0] chip_i,
    input  logic             mode_i,
    input  logic             ext_en_i,
    input  logic [N_MAX-1:0] root_i,
    output logic             sym_valid_o,
    output logic [SYM_W-1:0] sym_idx_o,
    output logic [ACC_W-1:0] peak_o
);

    cd_step_t         step;
    cd_mode_e         mode_q;
    logic [N_MAX-1:0] root_q;
    logic [N_MAX-1:0] ref_bits;
    acc_t [N_MAX-1:0] sums;
    cd_pick_t         pick;

    cd_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sym_start_i  (sym_start_i),
        .chip_valid_i (chip_valid_i),
        .mode_i       (mode_i),
        .ext_en_i     (ext_en_i),
        .root_i       (root_i),
        .step_o       (step),
        .mode_o       (mode_q),
        .root_o       (root_q)
    );

    cd_refgen u_refgen (
        .mode_i (mode_q),
        .root_i (root_q),
        .pos_i  (step.pos),
        .ref_o  (ref_bits)
    );

    cd_corr_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (step.clear),
        .acc_en_i (step.acc_en),
        .chip_i   (chip_t'(chip_i)),
        .ref_i    (ref_bits),
        .sum_o    (sums)
    );

    cd_peak_pick u_pick (
        .mode_i (mode_q),
        .sum_i  (sums),
        .pick_o (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid_o <= 1'b0;
            sym_idx_o   <= '0;
            peak_o      <= '0;
        end else begin
            sym_valid_o <= step.last;
            if (step.last) begin
                sym_idx_o <= pick.idx;
                peak_o    <= pick.peak;
            end
        end
    end

endmodule

// File: rtl/cd_checker.sv
module cd_checker
    import cd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sym_start_i,
    input logic             chip_valid_i,
    input logic             mode_i,
    input logic             ext_en_i,
    input logic             sym_valid_o,
    input logic [SYM_W-1:0] sym_idx_o
);

    logic             c_act;
    logic             c_long;
    logic             c_ext;
    logic [CNT_W-1:0] c_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_act  <= 1'b0;
            c_long <= 1'b0;
            c_ext  <= 1'b0;
            c_cnt  <= '0;
        end else if (sym_start_i) begin
            c_act  <= 1'b1;
            c_long <= mode_i;
            c_ext  <= ext_en_i;
            c_cnt  <= '0;
        end else begin
            if (c_act && chip_valid_i)
                c_cnt <= c_cnt + 1'b1;
            if (sym_valid_o)
                c_act <= 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sym_valid_o);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid_o |=> !sym_valid_o);

    // R7
    after_chip_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid_o |-> $past(chip_valid_i));

    // R8
    start_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        sym_start_i |=> !sym_valid_o);

    // R6
    chip_count_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid_o |-> (c_act && (c_cnt == (c_long ? CNT_W'(N_MAX) : CNT_W'(N_MAX/2))
                                           + {{(CNT_W-1){1'b0}}, c_ext})));

    // R3
    short_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid_o && !c_long) |-> !sym_idx_o[SYM_W-1]);

endmodule

bind coh_despreader cd_checker u_chk (.*);

// File: tb/tb_coh_despreader.sv
module tb_coh_despreader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_start_i = 1'b0;
    logic        chip_valid_i = 1'b0;
    logic [5:0]  chip_i = '0;
    logic        mode_i = 1'b0;
    logic        ext_en_i = 1'b0;
    logic [15:0] root_i = '0;
    logic        sym_valid_o;
    logic [3:0]  sym_idx_o;
    logic [10:0] peak_o;

    always #5 clk = ~clk;

    coh_despreader dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int n_out   = 0;
    int n_sent  = 0;
    bit done    = 1'b0;
    logic [31:0] lfsr = 32'h1D2C3B4A;

    int exp_idx_q[$];
    int exp_pk_q[$];
    string exp_tag_q[$];

    int sc[17];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % m;
    endfunction

    // Candidate bit built by explicit rotation of the root
    function automatic bit cand_bit(input bit m16, input logic [15:0] root, input int k, input int j);
        int n;
        int half;
        bit s[16];
        bit t;
        n = m16 ? 16 : 8;
        half = n / 2;
        for (int i = 0; i < n; i++) s[i] = root[i];
        for (int r = 0; r < 2 * (k % half); r++) begin
            t = s[n-1];
            for (int i = n - 1; i > 0; i--) s[i] = s[i-1];
            s[0] = t;
        end
        if (k >= half && (j % 2 == 1)) return ~s[j];
        return s[j];
    endfunction

    function automatic int corr(input bit m16, input logic [15:0] root, input int k, input bit ext);
        int n;
        int acc;
        n = m16 ? 16 : 8;
        acc = 0;
        for (int j = 0; j < n; j++)
            acc += cand_bit(m16, root, k, j) ? sc[j + int'(ext)] : -sc[j + int'(ext)];
        return acc;
    endfunction

    task automatic fill(input bit m16, input logic [15:0] root, input int k, input int amp,
                        input int noise, input bit ext);
        int n;
        int v;
        n = m16 ? 16 : 8;
        for (int i = 0; i < 17; i++) sc[i] = 0;
        if (ext) sc[0] = rnd(64) - 32;
        for (int j = 0; j < n; j++) begin
            v = cand_bit(m16, root, k, j) ? amp : -amp;
            if (noise > 0) v += rnd(2 * noise + 1) - noise;
            if (v > 31) v = 31;
            if (v < -32) v = -32;
            sc[j + int'(ext)] = v;
        end
    endtask

    task automatic send(input bit m16, input bit ext, input logic [15:0] root,
                        input int gaps, input bit chip_at_start, input string tag);
        int n;
        int best;
        int bidx;
        int c;
        n = m16 ? 16 : 8;
        best = corr(m16, root, 0, ext);
        bidx = 0;
        for (int k = 1; k < n; k++) begin
            c = corr(m16, root, k, ext);
            if (c > best) begin best = c; bidx = k; end
        end
        exp_idx_q.push_back(bidx);
        exp_pk_q.push_back(best);
        exp_tag_q.push_back(tag);
        n_sent++;
        @(negedge clk);
        sym_start_i  = 1'b1;
        mode_i       = m16;
        ext_en_i     = ext;
        root_i       = root;
        chip_valid_i = chip_at_start;
        chip_i       = 6'sd31;
        @(negedge clk);
        sym_start_i  = 1'b0;
        mode_i       = ~m16;
        ext_en_i     = ~ext;
        root_i       = ~root;
        for (int i = 0; i < n + int'(ext); i++) begin
            if (gaps > 0 && (i % 2 == 1)) begin
                chip_valid_i = 1'b0;
                chip_i = 6'h15;
                repeat (gaps) @(negedge clk);
            end
            chip_valid_i = 1'b1;
            chip_i = 6'(sc[i]);
            @(negedge clk);
        end
        chip_valid_i = 1'b0;
        // R7: pulse visible in the cycle after the final chip
        chk(sym_valid_o === 1'b1, {"R7 valid after last chip ", tag}, int'(sym_valid_o), 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && sym_valid_o) begin
            n_out++;
            if (exp_idx_q.size() == 0) begin
                chk(1'b0, "R9 unexpected output", int'(sym_idx_o), -1);
            end else begin
                int ei;
                int ep;
                string et;
                ei = exp_idx_q.pop_front();
                ep = exp_pk_q.pop_front();
                et = exp_tag_q.pop_front();
                chk(int'(sym_idx_o) == ei, {et, " index"}, int'(sym_idx_o), ei);
                chk(int'($signed(peak_o)) == ep, {et, " peak"}, int'($signed(peak_o)), ep);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sym_valid_o === 1'b0, "R1 valid", int'(sym_valid_o), 0);
        chk(sym_idx_o === 4'd0, "R1 index", int'(sym_idx_o), 0);
        chk(peak_o === 11'd0, "R1 peak", int'(peak_o), 0);

        // R2: every 16-chip candidate, clean
        for (int k = 0; k < 16; k++) begin
            fill(1'b1, 16'h077B, k, 12 + k, 0, 1'b0);
            send(1'b1, 1'b0, 16'h077B, 0, 1'b0, "R2 long clean");
        end
        // R3 + R6: every 8-chip candidate with extension chip
        for (int k = 0; k < 8; k++) begin
            fill(1'b0, 16'hA55C, k, 20, 0, 1'b1);
            send(1'b0, 1'b1, 16'hA55C, 0, 1'b0, "R3 R6 short ext");
        end
        // R6: long mode with extension and gaps (R7)
        for (int k = 0; k < 16; k += 3) begin
            fill(1'b1, 16'h2F53, k, 9, 0, 1'b1);
            send(1'b1, 1'b1, 16'h2F53, 2, 1'b0, "R6 R7 long ext gaps");
        end
        // R4: noisy symbols, exact sums
        for (int t = 0; t < 24; t++) begin
            bit m;
            bit e;
            m = (t % 2 == 0);
            e = (t % 3 == 0);
            fill(m, 16'h3AFC, rnd(m ? 16 : 8), 10, 14, e);
            send(m, e, 16'h3AFC, t % 3, 1'b0, "R4 noisy");
        end
        // R4: full-scale negative chips
        for (int i = 0; i < 17; i++) sc[i] = -32;
        send(1'b1, 1'b0, 16'hFFFF, 0, 1'b0, "R4 full scale");
        // R5: all zero chips, every correlation ties at 0
        for (int i = 0; i < 17; i++) sc[i] = 0;
        send(1'b1, 1'b0, 16'h077B, 0, 1'b0, "R5 tie zero long");
        send(1'b0, 1'b1, 16'h005C, 0, 1'b0, "R5 tie zero short");
        // R8: chip in start cycle ignored
        fill(1'b0, 16'h0045, 5, 15, 0, 1'b0);
        send(1'b0, 1'b0, 16'h0045, 0, 1'b1, "R8 chip at start");
        // R8: abandoned partial symbol yields nothing
        @(negedge clk);
        sym_start_i = 1'b1; mode_i = 1'b1; root_i = 16'h1234;
        @(negedge clk);
        sym_start_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chip_valid_i = 1'b1; chip_i = 6'd25;
            @(negedge clk);
        end
        chip_valid_i = 1'b0;
        fill(1'b1, 16'h077B, 11, 18, 0, 1'b0);
        send(1'b1, 1'b0, 16'h077B, 0, 1'b0, "R8 after abandon");
        // R9: chips after completion with no strobe
        for (int i = 0; i < 20; i++) begin
            chip_valid_i = 1'b1; chip_i = 6'(i);
            @(negedge clk);
            chk(sym_valid_o === 1'b0, "R9 idle chips", int'(sym_valid_o), 0);
        end
        chip_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        // R8 R9: output count matches symbols sent
        chk(n_out == n_sent, "R8 R9 output count", n_out, n_sent);
        finish_run();
    end

endmodule